// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block decides, cycle by cycle, whether each of up to two motor power bridges may conduct. It watches a raw overcurrent flag per bridge, a digitized die temperature code and a digitized supply voltage code, and combines them with an external enable request per bridge. For each bridge it produces a "bridge allowed" output and a fault pull-down indication that models an open-drain device pulling that bridge's shared enable line low.

An overcurrent flag is first synchronized and must persist before it counts. After a programmable detection delay, that bridge alone is switched off and its pull-down asserts for a programmable number of cycles. The bridge then comes back without any outside help, unless the overcurrent is still present, in which case the off period starts again. Over-temperature and low supply each act as a lockout with separate entry and exit codes, and both force every bridge off. The thermal lockout also drives the pull-down of every bridge. Reset places both lockouts in their asserted state, so no bridge turns on until the supply code first rises past its release code.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While reset is high and after it falls, `bridge_on` is all zero until `vsup_code` has been sampled above the supply release code; with a cool die, `fault_pull` is all zero from the second cycle after reset.
- R2: The supply lockout releases on the clock edge that samples `vsup_code` > 70 and asserts on the edge that samples `vsup_code` < 60; codes 60 through 70 keep the current state.
- R3: The thermal lockout asserts on the edge that samples `temp_code` >= 165 and releases on the edge that samples `temp_code` <= 150; codes 151 through 164 keep the state. While it is asserted, every bit of `bridge_on` is 0 and every bit of `fault_pull` is 1.
- R4: An overcurrent flag that is high for only one sampled clock edge has no effect on `bridge_on` or `fault_pull`.
- R5: When `oc_flag[i]` is first sampled high at edge k and stays high, bridge i turns off and `fault_pull[i]` rises after edge k+3+`delay_cycles`.
- R6: Bridge i then stays off with `fault_pull[i]` high for exactly `disable_cycles` cycles (minimum 1), after which it turns back on by itself if the qualified overcurrent has cleared.
- R7: If the qualified overcurrent is still present when the off period ends, the off period restarts for another `disable_cycles` cycles.
- R8: An overcurrent on one bridge changes neither `bridge_on` nor `fault_pull` of the other bridge.
- R9: `en_req[i]` low forces `bridge_on[i]` to 0 in the same cycle and does not affect `fault_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | NUM_BRIDGES | External enable request per bridge |
| oc_flag | input | NUM_BRIDGES | Raw, asynchronous overcurrent flag per bridge |
| temp_code | input | TEMP_W | Digitized die temperature |
| vsup_code | input | VSUP_W | Digitized supply voltage |
| delay_cycles | input | CNT_W | Cycles from qualified overcurrent to switch-off |
| disable_cycles | input | CNT_W | Length of the overcurrent off period in cycles |
| bridge_on | output | NUM_BRIDGES | Bridge may conduct |
| fault_pull | output | NUM_BRIDGES | Pull-down on the bridge's enable line |

## Verification
Each stimulus carries its own due cycle: a lockout code takes effect one edge after it is driven, an enable request is visible at the next sample, and an overcurrent takes four edges plus the detection delay, then the off period ends exactly `disable_cycles` edges later. The driver records every expected output together with the absolute cycle at which it is due, and the monitor compares only in that cycle, on the falling clock edge, so both the last cycle before and the first cycle after every transition are checked. Each scenario waits until all its expectations are consumed before the next one starts.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_DELAY = 2'd1,
        OC_HOLD  = 2'd2
    } oc_state_e;

    typedef struct packed {
        logic thermal;
        logic supply;
    } lockout_t;

    localparam int TEMP_TRIP_DEF    = 165;
    localparam int TEMP_RELEASE_DEF = 150;
    localparam int VSUP_TRIP_DEF    = 60;
    localparam int VSUP_RELEASE_DEF = 70;

    function automatic logic count_ends(input logic [31:0] cnt);
        return cnt <= 32'd1;
    endfunction

endpackage

// File: rtl/bfs_oc_qualify.sv
module bfs_oc_qualify #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_flag,
    output logic qualified
);
    localparam int HIST_W = (QUAL_CYCLES > 1) ? QUAL_CYCLES - 1 : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_flag};
        end
    end

    generate
        if (QUAL_CYCLES > 1) begin : g_hist
            if (HIST_W > 1) begin : g_wide
                always_ff @(posedge clk) begin
                    if (rst) hist_q <= '0;
                    else     hist_q <= {hist_q[HIST_W-2:0], synced};
                end
            end else begin : g_one
                always_ff @(posedge clk) begin
                    if (rst) hist_q <= '0;
                    else     hist_q <= synced;
                end
            end
            assign qualified = synced & (&hist_q);
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= '0;
            end
            assign qualified = synced;
        end
    endgenerate

endmodule

// File: rtl/bfs_oc_timer.sv
module bfs_oc_timer
    import bfs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oc_qual,
    input  logic [CNT_W-1:0] delay_cycles,
    input  logic [CNT_W-1:0] disable_cycles,
    output logic             holding
);
    oc_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_count;

    assign last_count = count_ends(32'(cnt_q));
    assign holding    = (state_q == OC_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OC_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                OC_IDLE: begin
                    if (oc_qual) begin
                        if (delay_cycles == '0) begin
                            state_q <= OC_HOLD;
                            cnt_q   <= disable_cycles;
                        end else begin
                            state_q <= OC_DELAY;
                            cnt_q   <= delay_cycles;
                        end
                    end
                end
                OC_DELAY: begin
                    if (last_count) begin
                        state_q <= OC_HOLD;
                        cnt_q   <= disable_cycles;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                OC_HOLD: begin
                    if (last_count) begin
                        if (oc_qual) begin
                            cnt_q <= disable_cycles;
                        end else begin
                            state_q <= OC_IDLE;
                            cnt_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= OC_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bfs_hyst_lock.sv
module bfs_hyst_lock #(
    parameter int CODE_W       = 8,
    parameter int TRIP_CODE    = 165,
    parameter int RELEASE_CODE = 150,
    parameter bit TRIP_HIGH    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              locked
);
    localparam logic [CODE_W-1:0] TRIP_V = CODE_W'(TRIP_CODE);
    localparam logic [CODE_W-1:0] REL_V  = CODE_W'(RELEASE_CODE);

    logic trip_hit;
    logic release_hit;

    generate
        if (TRIP_HIGH) begin : g_over
            assign trip_hit    = (code >= TRIP_V);
            assign release_hit = (code <= REL_V);
        end else begin : g_under
            assign trip_hit    = (code < TRIP_V);
            assign release_hit = (code > REL_V);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b1;
        end else if (locked) begin
            if (release_hit) locked <= 1'b0;
        end else if (trip_hit) begin
            locked <= 1'b1;
        end
    end

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
    import bfs_pkg::*;
#(
    parameter int NUM_BRIDGES  = 2,
    parameter int TEMP_W       = 8,
    parameter int VSUP_W       = 8,
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_CYCLES  = 2,
    parameter int TEMP_TRIP    = TEMP_TRIP_DEF,
    parameter int TEMP_RELEASE = TEMP_RELEASE_DEF,
    parameter int VSUP_TRIP    = VSUP_TRIP_DEF,
    parameter int VSUP_RELEASE = VSUP_RELEASE_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_BRIDGES-1:0] en_req,
    input  logic [NUM_BRIDGES-1:0] oc_flag,
    input  logic [TEMP_W-1:0]      temp_code,
    input  logic [VSUP_W-1:0]      vsup_code,
    input  logic [CNT_W-1:0]       delay_cycles,
    input  logic [CNT_W-1:0]       disable_cycles,
    output logic [NUM_BRIDGES-1:0] bridge_on,
    output logic [NUM_BRIDGES-1:0] fault_pull
);
    lockout_t               lock;
    logic [NUM_BRIDGES-1:0] oc_hold;

    bfs_hyst_lock #(
        .CODE_W(TEMP_W), .TRIP_CODE(TEMP_TRIP),
        .RELEASE_CODE(TEMP_RELEASE), .TRIP_HIGH(1'b1)
    ) u_thermal (
        .clk(clk), .rst(rst), .code(temp_code), .locked(lock.thermal)
    );

    bfs_hyst_lock #(
        .CODE_W(VSUP_W), .TRIP_CODE(VSUP_TRIP),
        .RELEASE_CODE(VSUP_RELEASE), .TRIP_HIGH(1'b0)
    ) u_supply (
        .clk(clk), .rst(rst), .code(vsup_code), .locked(lock.supply)
    );

    generate
        for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
            logic oc_qual;

            bfs_oc_qualify #(
                .SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)
            ) u_qual (
                .clk(clk), .rst(rst), .raw_flag(oc_flag[b]), .qualified(oc_qual)
            );

            bfs_oc_timer #(.CNT_W(CNT_W)) u_timer (
                .clk(clk), .rst(rst), .oc_qual(oc_qual),
                .delay_cycles(delay_cycles), .disable_cycles(disable_cycles),
                .holding(oc_hold[b])
            );

            assign fault_pull[b] = oc_hold[b] | lock.thermal;
            assign bridge_on[b]  = en_req[b] & ~fault_pull[b] & ~lock.supply;
        end
    endgenerate

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
    parameter int NUM_BRIDGES  = 2,
    parameter int TEMP_W       = 8,
    parameter int VSUP_W       = 8,
    parameter int TEMP_TRIP    = 165,
    parameter int VSUP_TRIP    = 60
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_BRIDGES-1:0] en_req,
    input logic [TEMP_W-1:0]      temp_code,
    input logic [VSUP_W-1:0]      vsup_code,
    input logic [NUM_BRIDGES-1:0] bridge_on,
    input logic [NUM_BRIDGES-1:0] fault_pull
);
    a_r1_off_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bridge_on == '0));

    a_r2_low_supply_off: assert property (@(posedge clk) disable iff (rst)
        (vsup_code < VSUP_W'(VSUP_TRIP)) |=> (bridge_on == '0));

    a_r3_hot_die_off: assert property (@(posedge clk) disable iff (rst)
        (temp_code >= TEMP_W'(TEMP_TRIP)) |=> ((bridge_on == '0) && (&fault_pull)));

    a_r9_request_gates: assert property (@(posedge clk) disable iff (rst)
        ((bridge_on & ~en_req) == '0));

    a_r6_pull_means_off: assert property (@(posedge clk) disable iff (rst)
        ((bridge_on & fault_pull) == '0));

endmodule

bind bridge_fault_supervisor bfs_checker #(
    .NUM_BRIDGES(NUM_BRIDGES), .TEMP_W(TEMP_W), .VSUP_W(VSUP_W),
    .TEMP_TRIP(TEMP_TRIP), .VSUP_TRIP(VSUP_TRIP)
) u_bfs_checker (
    .clk(clk), .rst(rst), .en_req(en_req), .temp_code(temp_code),
    .vsup_code(vsup_code), .bridge_on(bridge_on), .fault_pull(fault_pull)
);

// File: tb/bridge_fault_supervisor_test.sv
module bridge_fault_supervisor_test;

    localparam int NB = 2;

    typedef struct {
        int unsigned at;
        logic [NB-1:0] on;
        logic [NB-1:0] pull;
        string tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] en_req = '1;
    logic [NB-1:0] oc_flag = '0;
    logic [7:0]    temp_code = 8'd25;
    logic [7:0]    vsup_code = 8'd0;
    logic [15:0]   delay_cycles = 16'd2;
    logic [15:0]   disable_cycles = 16'd5;
    logic [NB-1:0] bridge_on;
    logic [NB-1:0] fault_pull;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_item_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bridge_fault_supervisor uut (
        .clk(clk), .rst(rst), .en_req(en_req), .oc_flag(oc_flag),
        .temp_code(temp_code), .vsup_code(vsup_code),
        .delay_cycles(delay_cycles), .disable_cycles(disable_cycles),
        .bridge_on(bridge_on), .fault_pull(fault_pull)
    );

    // monitor: compares each expectation in the cycle it is due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_item_t it;
            it = sb.pop_front();
            checks++;
            if (it.at != cyc || bridge_on !== it.on || fault_pull !== it.pull) begin
                errors++;
                $display("FAIL %s: cycle %0d bridge_on=%b fault_pull=%b expected %b %b",
                         it.tag, cyc, bridge_on, fault_pull, it.on, it.pull);
            end
        end
    end

    task automatic expect_in(input int off, input logic [NB-1:0] on,
                             input logic [NB-1:0] pull, input string tag);
        sb.push_back('{cyc + off, on, pull, tag});
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        step(3);
        // R1: outputs during reset
        checks++;
        if (bridge_on !== 2'b00) begin
            errors++;
            $display("FAIL R1: bridge_on=%b during reset expected 00", bridge_on);
        end
        rst = 1'b0;
        expect_in(2, 2'b00, 2'b00, "R1 off until supply release");
        expect_in(4, 2'b00, 2'b00, "R1 still off");
        drain();

        // R2: supply hysteresis
        vsup_code = 8'd70;
        expect_in(1, 2'b00, 2'b00, "R2 code 70 keeps lockout");
        expect_in(2, 2'b00, 2'b00, "R2 code 70 keeps lockout");
        drain();
        vsup_code = 8'd71;
        expect_in(1, 2'b11, 2'b00, "R2 release above 70");
        drain();
        vsup_code = 8'd60;
        expect_in(2, 2'b11, 2'b00, "R2 code 60 stays released");
        drain();
        vsup_code = 8'd59;
        expect_in(1, 2'b00, 2'b00, "R2 lockout below 60");
        drain();
        vsup_code = 8'd71;
        expect_in(1, 2'b11, 2'b00, "R2 release again");
        drain();

        // R3: thermal hysteresis
        temp_code = 8'd164;
        expect_in(1, 2'b11, 2'b00, "R3 code 164 no trip");
        drain();
        temp_code = 8'd165;
        expect_in(1, 2'b00, 2'b11, "R3 trip at 165");
        drain();
        temp_code = 8'd151;
        expect_in(2, 2'b00, 2'b11, "R3 code 151 holds lockout");
        drain();
        temp_code = 8'd150;
        expect_in(1, 2'b11, 2'b00, "R3 release at 150");
        drain();

        // R4: single-edge glitch ignored
        oc_flag = 2'b01;
        for (int i = 1; i <= 8; i++) expect_in(i, 2'b11, 2'b00, "R4 glitch ignored");
        step(1);
        oc_flag = 2'b00;
        drain();

        // R5, R6, R8: delay 2, off for 5 cycles on bridge 0
        oc_flag = 2'b01;
        expect_in(5, 2'b11, 2'b00, "R5 still on before delay ends");
        expect_in(6, 2'b10, 2'b01, "R5 off after delay; R8 bridge 1 on");
        expect_in(10, 2'b10, 2'b01, "R6 last off cycle");
        expect_in(11, 2'b11, 2'b00, "R6 automatic recovery");
        step(4);
        oc_flag = 2'b00;
        drain();

        // R7, R8: restart on bridge 1
        oc_flag = 2'b10;
        expect_in(6, 2'b01, 2'b10, "R8 bridge 0 unaffected");
        expect_in(11, 2'b01, 2'b10, "R7 off period restarts");
        expect_in(15, 2'b01, 2'b10, "R7 second period");
        expect_in(16, 2'b11, 2'b00, "R7 recovery after restart");
        step(12);
        oc_flag = 2'b00;
        drain();

        // R5, R6: zero delay, off for 3 cycles
        delay_cycles = 16'd0;
        disable_cycles = 16'd3;
        oc_flag = 2'b01;
        expect_in(3, 2'b11, 2'b00, "R5 zero delay on before");
        expect_in(4, 2'b10, 2'b01, "R5 zero delay switch-off");
        expect_in(6, 2'b10, 2'b01, "R6 three-cycle hold");
        expect_in(7, 2'b11, 2'b00, "R6 recovery after 3");
        step(2);
        oc_flag = 2'b00;
        drain();

        // R9: request gating
        en_req = 2'b01;
        expect_in(1, 2'b01, 2'b00, "R9 request low blocks bridge 1");
        drain();
        en_req = 2'b00;
        expect_in(1, 2'b00, 2'b00, "R9 both requests low");
        drain();
        en_req = 2'b11;
        expect_in(1, 2'b11, 2'b00, "R9 requests restored");
        drain();

        step(2);
        finish_run();
    end

endmodule